// File: doc/BRIEF.md
# Frequent-Opcode Dictionary Codec

This block compresses and expands streams of Java bytecode bytes on the fly. A sixteen-entry dictionary holds the opcodes a program uses most; software loads it through a small write port. The encoder looks up each byte as it arrives. A byte found in the dictionary becomes a five-bit code: a set flag bit followed by the dictionary slot number. Any other byte becomes a nine-bit code: a clear flag bit followed by the byte itself. The encoder packs these codes into 32-bit words. The decoder takes such words and restores the original bytes in order.

Both directions use valid/ready handshakes. The encoder marks the final byte of a stream with a last flag. It then flushes the partly filled word and reports how many of its bits carry codes. The decoder uses that count to ignore the padding, which would otherwise read as extra raw bytes. The dictionary can change only while both directions are empty, so no stream is ever coded under two different tables.

Top module: `fbc_codec`

## Requirements
- R1: A byte equal to dictionary entry k is coded as five bits: a 1, then k as four bits, most significant bit first.
- R2: A byte matching no entry is coded as nine bits: a 0, then the eight byte bits, most significant bit first.
- R3: When several entries hold the same value, the encoder uses the lowest slot number.
- R4: Codes are placed into 32-bit words starting at bit 31, each code directly after the previous one, with no gaps. A code may span two words.
- R5: A byte sent with the last flag ends the stream. The word holding its code is emitted with the last flag set and with its unused low bits zero. Its bit count (1 to 32) gives the number of code bits; every earlier word reports 32.
- R6: Under backpressure no byte or word is lost or reordered. A presented word stays stable until it is accepted.
- R7: The decoder turns a word stream back into the original byte sequence, maps each five-bit code through the dictionary, and flags the byte that ends the final word.
- R8: In the decoder's final word, bits beyond the given bit count are ignored, whatever their values.
- R9: A dictionary write is dropped unless the encoder and the decoder are both empty. An accepted write takes effect for the following bytes.
- R10: A lone last byte accepted at clock edge k gives a valid encoder word after edge k+1, not after edge k. A word accepted by the decoder at edge k gives a valid byte after edge k+1, not after edge k.
- R11: After reset no output is valid and both inputs are ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Dictionary write strobe |
| tbl_addr | input | 4 | Dictionary slot to write |
| tbl_wdata | input | 8 | Opcode value to store |
| enc_in_valid | input | 1 | Encoder byte valid |
| enc_in_ready | output | 1 | Encoder can take a byte |
| enc_in_byte | input | 8 | Bytecode byte to compress |
| enc_in_last | input | 1 | Byte ends the stream |
| enc_out_valid | output | 1 | Packed word valid |
| enc_out_ready | input | 1 | Consumer takes the packed word |
| enc_out_word | output | 32 | Packed word, first code at bit 31 |
| enc_out_last | output | 1 | Final word of the stream |
| enc_out_nbits | output | 6 | Code bits in this word |
| dec_in_valid | input | 1 | Decoder word valid |
| dec_in_ready | output | 1 | Decoder can take a word |
| dec_in_word | input | 32 | Packed word to expand |
| dec_in_last | input | 1 | Final word of the stream |
| dec_in_nbits | input | 6 | Code bits in the final word |
| dec_out_valid | output | 1 | Restored byte valid |
| dec_out_ready | input | 1 | Consumer takes the byte |
| dec_out_byte | output | 8 | Restored bytecode byte |
| dec_out_last | output | 1 | Byte ends the stream |

## Verification
The encoder has two register steps between a byte and its word: the lookup stage and the pack register. A single last byte therefore shows a valid word after the second edge. The bench looks at the output half a cycle after each of those two edges and requires it to be absent after the first and present after the second. The decoder likewise fills its bit buffer at the edge that accepts a word, and moves the first code into its output stage at the next edge. The bench checks it at the same two points. The streaming tests do not depend on cycle counts: they record every handshake half a clock before the edge that completes it and compare the recorded words and bytes, in order, against a bit-level model computed inside the bench.

// File: rtl/fbc_pkg.sv
package fbc_pkg;
   localparam int FBC_WORD_W = 32;
   localparam int FBC_BYTE_W = 8;
   localparam int FBC_IDX_W  = 4;
endpackage

// File: rtl/fbc_dict.sv
module fbc_dict #(
   parameter int RAW  = 8,
   parameter int IDXW = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          we,
   input  logic [IDXW-1:0]               waddr,
   input  logic [RAW-1:0]                wdata,
   output logic [(1<<IDXW)*RAW-1:0]      entries
);
   localparam int ENT = 1 << IDXW;

   generate
      for (genvar g = 0; g < ENT; g++) begin : g_slot
         always_ff @(posedge clk) begin
            if (!rst_n)
               entries[g*RAW +: RAW] <= '0;
            else if (we && (waddr == IDXW'(g)))
               entries[g*RAW +: RAW] <= wdata;
         end
      end
   endgenerate
endmodule

// File: rtl/fbc_enc.sv
module fbc_enc #(
   parameter int W    = 32,
   parameter int RAW  = 8,
   parameter int IDXW = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [(1<<IDXW)*RAW-1:0]    entries,
   input  logic                        in_valid,
   output logic                        in_ready,
   input  logic [RAW-1:0]              in_byte,
   input  logic                        in_last,
   output logic                        out_valid,
   input  logic                        out_ready,
   output logic [W-1:0]                out_word,
   output logic                        out_last,
   output logic [$clog2(W+1)-1:0]      out_nbits,
   output logic                        idle
);
   localparam int ENT = 1 << IDXW;
   localparam int CL  = 1 + RAW;
   localparam int HL  = 1 + IDXW;
   localparam int EBW = W + CL - 1;
   localparam int CW  = $clog2(EBW + 1);
   localparam int NBW = $clog2(W + 1);

   generate
      if (HL >= CL) begin : g_bad_idx
         $error("index code must be shorter than raw code");
      end
      if (W < CL) begin : g_bad_word
         $error("word narrower than one raw code");
      end
   endgenerate

   // dictionary compare, one comparator per slot
   logic [ENT-1:0]  hitv;
   logic            found;
   logic [IDXW-1:0] fidx;

   generate
      for (genvar g = 0; g < ENT; g++) begin : g_cmp
         assign hitv[g] = (entries[g*RAW +: RAW] == in_byte);
      end
   endgenerate

   always_comb begin
      found = 1'b0;
      fidx  = '0;
      for (int i = ENT - 1; i >= 0; i--) begin
         if (hitv[i]) begin
            found = 1'b1;
            fidx  = IDXW'(i);
         end
      end
   end

   // lookup stage
   logic            s_v, s_hit, s_last;
   logic [IDXW-1:0] s_idx;
   logic [RAW-1:0]  s_byte;

   // pack register
   logic [EBW-1:0]  pbuf;
   logic [CW-1:0]   cnt;
   logic            flush;

   logic            pop, app, fits;
   logic [CW-1:0]   cnt_pop, len;
   logic [EBW-1:0]  buf_pop, ext;
   logic [CL-1:0]   code;

   assign code = s_hit ? {1'b1, s_idx, {(CL-HL){1'b0}}} : {1'b0, s_byte};
   assign len  = s_hit ? CW'(HL) : CW'(CL);

   assign out_valid = (cnt >= CW'(W)) || (flush && (cnt != '0));
   assign out_word  = pbuf[EBW-1 -: W];
   assign out_last  = flush && (cnt <= CW'(W));
   assign out_nbits = (cnt >= CW'(W)) ? NBW'(W) : NBW'(cnt);

   assign pop     = out_valid && out_ready;
   assign cnt_pop = pop ? ((cnt >= CW'(W)) ? cnt - CW'(W) : '0) : cnt;
   assign buf_pop = pop ? (pbuf << W) : pbuf;
   assign fits    = ({1'b0, cnt_pop} + {1'b0, len}) <= (CW+1)'(EBW);
   assign app     = s_v && fits;
   assign ext     = {code, {(EBW-CL){1'b0}}} >> cnt_pop;

   assign in_ready = !flush && (!s_v || (app && !s_last));
   assign idle     = !s_v && !flush && (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s_v    <= 1'b0;
         s_hit  <= 1'b0;
         s_last <= 1'b0;
         s_idx  <= '0;
         s_byte <= '0;
      end else if (in_valid && in_ready) begin
         s_v    <= 1'b1;
         s_hit  <= found;
         s_idx  <= fidx;
         s_byte <= in_byte;
         s_last <= in_last;
      end else if (app) begin
         s_v    <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pbuf  <= '0;
         cnt   <= '0;
         flush <= 1'b0;
      end else begin
         pbuf <= buf_pop | (app ? ext : '0);
         cnt  <= cnt_pop + (app ? len : '0);
         if (app && s_last)
            flush <= 1'b1;
         else if (pop && (cnt_pop == '0))
            flush <= 1'b0;
      end
   end

   AST_ENC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_last)); // R6
   AST_ENC_FULL_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_last |-> out_nbits == NBW'(W)); // R5
   AST_ENC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(EBW)); // R4
   AST_ENC_TAKE_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> s_v); // R6
endmodule

// File: rtl/fbc_dec.sv
module fbc_dec #(
   parameter int W    = 32,
   parameter int RAW  = 8,
   parameter int IDXW = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [(1<<IDXW)*RAW-1:0]    entries,
   input  logic                        in_valid,
   output logic                        in_ready,
   input  logic [W-1:0]                in_word,
   input  logic                        in_last,
   input  logic [$clog2(W+1)-1:0]      in_nbits,
   output logic                        out_valid,
   input  logic                        out_ready,
   output logic [RAW-1:0]              out_byte,
   output logic                        out_last,
   output logic                        idle
);
   localparam int CL  = 1 + RAW;
   localparam int HL  = 1 + IDXW;
   localparam int DBW = W + RAW;
   localparam int CW  = $clog2(DBW + 1);
   localparam int NBW = $clog2(W + 1);

   generate
      if (W < CL) begin : g_bad_word
         $error("word narrower than one raw code");
      end
   endgenerate

   logic [DBW-1:0]  dbuf;
   logic [CW-1:0]   cnt;
   logic            got_last;

   logic            sv, s_hit, s_last;
   logic [RAW-1:0]  s_val;

   logic            head, take, load;
   logic [CW-1:0]   need, cnt_c, cnt_n;
   logic [DBW-1:0]  buf_c;
   logic [NBW-1:0]  nb;
   logic [W-1:0]    keep, masked;

   assign head  = dbuf[DBW-1];
   assign need  = head ? CW'(HL) : CW'(CL);
   assign take  = (cnt >= need) && (!sv || out_ready);
   assign cnt_c = take ? cnt - need : cnt;
   assign buf_c = take ? (head ? (dbuf << HL) : (dbuf << CL)) : dbuf;

   assign in_ready = !got_last && (cnt_c <= CW'(DBW - W));
   assign load     = in_valid && in_ready;
   assign nb       = in_last ? in_nbits : NBW'(W);
   assign keep     = ~({W{1'b1}} >> nb);
   assign masked   = in_word & keep;
   assign cnt_n    = cnt_c + (load ? CW'(nb) : '0);

   assign out_valid = sv;
   assign out_byte  = s_hit ? entries[s_val[IDXW-1:0]*RAW +: RAW] : s_val;
   assign out_last  = s_last;
   assign idle      = !sv && !got_last && (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dbuf     <= '0;
         cnt      <= '0;
         got_last <= 1'b0;
      end else begin
         dbuf <= buf_c | (load ? ({masked, {(DBW-W){1'b0}}} >> cnt_c) : '0);
         cnt  <= cnt_n;
         if (load && in_last)
            got_last <= 1'b1;
         else if (take && got_last && (cnt_c == '0))
            got_last <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sv     <= 1'b0;
         s_hit  <= 1'b0;
         s_last <= 1'b0;
         s_val  <= '0;
      end else if (take) begin
         sv     <= 1'b1;
         s_hit  <= head;
         s_val  <= head ? RAW'(dbuf[DBW-2 -: IDXW]) : dbuf[DBW-2 -: RAW];
         s_last <= got_last && (cnt_c == '0);
      end else if (out_ready) begin
         sv     <= 1'b0;
      end
   end

   AST_DEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_byte) && $stable(out_last)); // R7
   AST_DEC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DBW)); // R8
   AST_DEC_NO_LOAD_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
      got_last |-> !in_ready); // R8
endmodule

// File: rtl/fbc_codec.sv
module fbc_codec #(
   parameter int W    = fbc_pkg::FBC_WORD_W,
   parameter int RAW  = fbc_pkg::FBC_BYTE_W,
   parameter int IDXW = fbc_pkg::FBC_IDX_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      tbl_we,
   input  logic [IDXW-1:0]           tbl_addr,
   input  logic [RAW-1:0]            tbl_wdata,
   input  logic                      enc_in_valid,
   output logic                      enc_in_ready,
   input  logic [RAW-1:0]            enc_in_byte,
   input  logic                      enc_in_last,
   output logic                      enc_out_valid,
   input  logic                      enc_out_ready,
   output logic [W-1:0]              enc_out_word,
   output logic                      enc_out_last,
   output logic [$clog2(W+1)-1:0]    enc_out_nbits,
   input  logic                      dec_in_valid,
   output logic                      dec_in_ready,
   input  logic [W-1:0]              dec_in_word,
   input  logic                      dec_in_last,
   input  logic [$clog2(W+1)-1:0]    dec_in_nbits,
   output logic                      dec_out_valid,
   input  logic                      dec_out_ready,
   output logic [RAW-1:0]            dec_out_byte,
   output logic                      dec_out_last
);
   localparam int ENT = 1 << IDXW;

   logic [ENT*RAW-1:0] entries;
   logic               enc_idle, dec_idle, idle, we_ok;

   assign idle  = enc_idle && dec_idle;
   assign we_ok = tbl_we && idle;

   fbc_dict #(.RAW(RAW), .IDXW(IDXW)) dict_i (
      .clk(clk), .rst_n(rst_n), .we(we_ok), .waddr(tbl_addr),
      .wdata(tbl_wdata), .entries(entries));

   fbc_enc #(.W(W), .RAW(RAW), .IDXW(IDXW)) enc_i (
      .clk(clk), .rst_n(rst_n), .entries(entries),
      .in_valid(enc_in_valid), .in_ready(enc_in_ready),
      .in_byte(enc_in_byte), .in_last(enc_in_last),
      .out_valid(enc_out_valid), .out_ready(enc_out_ready),
      .out_word(enc_out_word), .out_last(enc_out_last),
      .out_nbits(enc_out_nbits), .idle(enc_idle));

   fbc_dec #(.W(W), .RAW(RAW), .IDXW(IDXW)) dec_i (
      .clk(clk), .rst_n(rst_n), .entries(entries),
      .in_valid(dec_in_valid), .in_ready(dec_in_ready),
      .in_word(dec_in_word), .in_last(dec_in_last),
      .in_nbits(dec_in_nbits),
      .out_valid(dec_out_valid), .out_ready(dec_out_ready),
      .out_byte(dec_out_byte), .out_last(dec_out_last),
      .idle(dec_idle));

   AST_TBL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      tbl_we && !idle |=> $stable(entries)); // R9
endmodule

// File: tb/fbc_codec_tb.sv
module fbc_codec_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tbl_we = 1'b0;
   logic [3:0]  tbl_addr = '0;
   logic [7:0]  tbl_wdata = '0;
   logic        enc_in_valid = 1'b0, enc_in_last = 1'b0;
   logic [7:0]  enc_in_byte = '0;
   logic        enc_in_ready, enc_out_valid, enc_out_last;
   logic        enc_out_ready = 1'b1;
   logic [31:0] enc_out_word;
   logic [5:0]  enc_out_nbits;
   logic        dec_in_valid = 1'b0, dec_in_last = 1'b0;
   logic [31:0] dec_in_word = '0;
   logic [5:0]  dec_in_nbits = '0;
   logic        dec_in_ready, dec_out_valid, dec_out_last;
   logic        dec_out_ready = 1'b1;
   logic [7:0]  dec_out_byte;

   always #5 clk = ~clk;

   fbc_codec dut_i (.*);

   int checks = 0, fails = 0, cyc = 0;
   bit done = 0;
   int enc_mode = 0, dec_mode = 0;

   logic [7:0]  tab [16];
   logic [7:0]  src [512];
   logic        bits [8192];
   int          nbits_m;
   logic [31:0] ew [256];
   logic [5:0]  enb [256];
   int          ewn;

   logic [31:0] gw [256];
   logic [5:0]  gnb [256];
   logic        glast [256];
   int          gwn;
   logic [7:0]  gb [512];
   logic        gbl [512];
   int          gbn;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   always @(posedge clk) cyc++;

   always @(negedge clk) begin
      enc_out_ready = (enc_mode == 0) ? 1'b1 : ((cyc % 3) != 1);
      dec_out_ready = (dec_mode == 0) ? 1'b1 : ((cyc % 4) != 2);
      #1;
      if (enc_out_valid && enc_out_ready && gwn < 256) begin
         gw[gwn] = enc_out_word; gnb[gwn] = enc_out_nbits; glast[gwn] = enc_out_last; gwn++;
      end
      if (dec_out_valid && dec_out_ready && gbn < 512) begin
         gb[gbn] = dec_out_byte; gbl[gbn] = dec_out_last; gbn++;
      end
   end

   task automatic model(input int n);
      nbits_m = 0;
      for (int i = 0; i < n; i++) begin
         int hit = -1;
         for (int k = 15; k >= 0; k--) if (tab[k] == src[i]) hit = k;
         if (hit >= 0) begin
            bits[nbits_m++] = 1'b1;
            for (int b = 3; b >= 0; b--) bits[nbits_m++] = hit[b];
         end else begin
            bits[nbits_m++] = 1'b0;
            for (int b = 7; b >= 0; b--) bits[nbits_m++] = src[i][b];
         end
      end
      ewn = (nbits_m + 31) / 32;
      for (int w = 0; w < ewn; w++) begin
         ew[w] = '0;
         for (int b = 0; b < 32; b++)
            if (w*32 + b < nbits_m) ew[w][31-b] = bits[w*32 + b];
         enb[w] = (w == ewn-1) ? 6'(nbits_m - 32*w) : 6'd32;
      end
   endtask

   task automatic tbl_write(input logic [3:0] a, input logic [7:0] d);
      tbl_we = 1'b1; tbl_addr = a; tbl_wdata = d;
      @(negedge clk);
      tbl_we = 1'b0;
   endtask

   task automatic enc_send(input int n, input bit end_last);
      for (int i = 0; i < n; i++) begin
         enc_in_valid = 1'b1; enc_in_byte = src[i];
         enc_in_last = end_last && (i == n-1);
         #2;
         while (!enc_in_ready) begin @(negedge clk); #2; end
         @(negedge clk);
      end
      enc_in_valid = 1'b0; enc_in_last = 1'b0;
   endtask

   task automatic dec_send(input int n);
      for (int i = 0; i < n; i++) begin
         dec_in_valid = 1'b1; dec_in_word = gw[i];
         dec_in_nbits = gnb[i]; dec_in_last = (i == n-1);
         #2;
         while (!dec_in_ready) begin @(negedge clk); #2; end
         @(negedge clk);
      end
      dec_in_valid = 1'b0; dec_in_last = 1'b0;
   endtask

   task automatic wait_enc();
      for (int t = 0; t < 3000; t++) begin
         if (gwn > 0 && glast[gwn-1]) break;
         @(negedge clk);
      end
      @(negedge clk);
   endtask

   task automatic wait_dec();
      for (int t = 0; t < 3000; t++) begin
         if (gbn > 0 && gbl[gbn-1]) break;
         @(negedge clk);
      end
      @(negedge clk);
   endtask

   // encode n bytes of src, compare words with the model, then decode them back
   task automatic roundtrip(input int n, input string tag);
      model(n);
      gwn = 0; gbn = 0;
      enc_send(n, 1'b1);
      wait_enc();
      check({tag, " word count"}, gwn, ewn);
      for (int w = 0; w < ewn && w < gwn; w++) begin
         check({tag, " word"}, gw[w], ew[w]);
         check({tag, " nbits"}, 32'(gnb[w]), 32'(enb[w]));
         check({tag, " word last"}, 32'(glast[w]), 32'(w == ewn-1));
      end
      dec_send(gwn);
      wait_dec();
      check({tag, " R7 byte count"}, gbn, n);
      for (int i = 0; i < n && i < gbn; i++) begin
         check({tag, " R7 byte"}, 32'(gb[i]), 32'(src[i]));
         check({tag, " R7 byte last"}, 32'(gbl[i]), 32'(i == n-1));
      end
   endtask

   task automatic fill_mix(input int n, input logic [15:0] seed);
      logic [15:0] x = seed;
      for (int i = 0; i < n; i++) begin
         x = {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
         src[i] = x[0] ? tab[x[4:1]] : x[15:8];
      end
   endtask

   task automatic test_reset();
      check("R11 enc_out_valid", 32'(enc_out_valid), 0);
      check("R11 dec_out_valid", 32'(dec_out_valid), 0);
      check("R11 enc_in_ready", 32'(enc_in_ready), 1);
      check("R11 dec_in_ready", 32'(dec_in_ready), 1);
   endtask

   task automatic test_latency();
      gwn = 0; gbn = 0;
      enc_in_valid = 1'b1; enc_in_byte = 8'hFF; enc_in_last = 1'b1;
      @(negedge clk);
      enc_in_valid = 1'b0; enc_in_last = 1'b0;
      #2 check("R10 enc not yet valid", 32'(enc_out_valid), 0);
      @(negedge clk);
      #2;
      check("R10 enc valid", 32'(enc_out_valid), 1);
      check("R2/R5 lone raw word", enc_out_word, 32'h7F80_0000);
      check("R5 lone nbits", 32'(enc_out_nbits), 9);
      check("R5 lone last", 32'(enc_out_last), 1);
      wait_enc();
      dec_in_valid = 1'b1; dec_in_word = 32'h7F80_0000; dec_in_nbits = 6'd9; dec_in_last = 1'b1;
      @(negedge clk);
      dec_in_valid = 1'b0; dec_in_last = 1'b0;
      #2 check("R10 dec not yet valid", 32'(dec_out_valid), 0);
      @(negedge clk);
      #2;
      check("R10 dec valid", 32'(dec_out_valid), 1);
      check("R10 dec byte", 32'(dec_out_byte), 32'hFF);
      check("R10 dec last", 32'(dec_out_last), 1);
      wait_dec();
   endtask

   task automatic test_mixed();
      for (int i = 0; i < 16; i++) src[i] = tab[15-i];
      src[16] = 8'h00; src[17] = 8'hFF; src[18] = tab[0]; src[19] = 8'h01;
      roundtrip(20, "R1/R2/R4/R5 mixed");
      src[0] = tab[7]; roundtrip(1, "R1 single hit");
   endtask

   task automatic test_backpressure();
      enc_mode = 1; dec_mode = 1;
      fill_mix(200, 16'hACE1);
      roundtrip(200, "R6 stalled stream");
      enc_mode = 0; dec_mode = 0;
      fill_mix(90, 16'h1234);
      roundtrip(90, "R4/R6 free stream");
   endtask

   task automatic test_dup();
      tbl_write(4'd9, tab[3]); tab[9] = tab[3];
      src[0] = tab[3]; src[1] = tab[3]; src[2] = 8'hA7;
      roundtrip(3, "R3 duplicate entry");
      tbl_write(4'd9, 8'hB1); tab[9] = 8'hB1;
   endtask

   task automatic test_pad();
      gbn = 0;
      dec_in_valid = 1'b1; dec_in_word = {1'b1, 4'd5, 27'h7FF_FFFF};
      dec_in_nbits = 6'd5; dec_in_last = 1'b1;
      #2; while (!dec_in_ready) begin @(negedge clk); #2; end
      @(negedge clk);
      dec_in_valid = 1'b0; dec_in_last = 1'b0;
      wait_dec();
      repeat (4) @(negedge clk);
      check("R8 padded byte count", gbn, 1);
      check("R8 padded byte", 32'(gb[0]), 32'(tab[5]));
      check("R8 padded last", 32'(gbl[0]), 1);
   endtask

   task automatic test_lock();
      model(0);
      gwn = 0; gbn = 0;
      src[0] = 8'hFF;
      enc_send(1, 1'b0);
      repeat (3) @(negedge clk);
      tbl_write(4'd0, 8'h77);
      src[0] = tab[0];
      enc_send(1, 1'b1);
      wait_enc();
      check("R9 busy write dropped count", gwn, 1);
      check("R9 busy write dropped word", gw[0], {1'b0, 8'hFF, 1'b1, 4'd0, 18'd0});
      tbl_write(4'd0, 8'h77); tab[0] = 8'h77;
      src[0] = 8'h77; src[1] = 8'h2A;
      roundtrip(2, "R9 idle write");
      tbl_write(4'd0, 8'h2A); tab[0] = 8'h2A;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run hung, got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      tab = '{8'h2A, 8'hB6, 8'h59, 8'h12, 8'h1B, 8'hB7, 8'h3C, 8'h84,
              8'hA7, 8'hB1, 8'h2B, 8'h4C, 8'hB4, 8'h10, 8'h60, 8'h99};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #2 test_reset();
      @(negedge clk);
      for (int i = 0; i < 16; i++) tbl_write(4'(i), tab[i]);
      test_latency();
      test_mixed();
      test_dup();
      test_pad();
      test_lock();
      test_backpressure();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule